// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers event flags from a network controller into one level-sensitive interrupt request. Event sources raise single-cycle set pulses that latch into a 32-bit main status register. A 32-bit main mask sits beside it, where a 1 in a mask bit silences the matching status bit. A separate 16-bit status and mask pair serves the management sub-unit, and any unmasked sub-unit bit appears in the main status as one summary source at bit 23.

Software reaches the registers over a simple 32-bit read/write bus. Read data is combinational from the current address. Reading the main status clears it, apart from bit 23. Reading the sub-unit status clears all of it. The main status and main mask can also be reached at a second pair of offsets, so older drivers that use those offsets keep working.

Top module: `irq_status_agg`

## Requirements
- R1: `irq` is high when any main status bit other than bit 23 is set and its main mask bit is 0. A mask bit of 1 blocks that status bit.
- R2: When any sub-unit status bit is set and its sub-unit mask bit is 0, a read of the main status returns bit 23 as 1 and `irq` is raised.
- R3: Bit 23 of the main mask has no effect on the sub-unit summary. A bit 23 that software writes into the main status never raises `irq` on its own.
- R4: A read of the main status (offset 0x100) returns the value before the read. It then clears every stored bit except bit 23.
- R5: A read of the sub-unit status (offset 0x200) returns its value and then clears all 16 bits.
- R6: Offset 0x108 behaves exactly like 0x100, and offset 0x10C behaves exactly like 0x104 (main mask), for both reads and writes.
- R7: A set pulse on a status bit wins over a clear-on-read or a software write in the same cycle, so the bit ends up set.
- R8: `irq` is registered. It changes on the clock edge after the status or mask change that causes it.
- R9: After reset, both status registers are 0, the main mask is 0xFF7FFFFF, the sub-unit mask is 0xFFFF and `irq` is 0.
- R10: The sub-unit mask is at offset 0x204 and reads back zero-extended. A read of any unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; triggers clear-on-read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_set | input | 32 | Set pulses into the main status bits |
| sub_set | input | 16 | Set pulses into the sub-unit status bits |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The assertions assume that the bus never raises a read and a write strobe in the same cycle, and one property checks this. The clear-on-read properties apply only in cycles with no set pulse, because the pulses deliberately override the clear. The bench keeps every access to a single strobe cycle. It places set pulses on a read or write cycle only in the tests that aim at the set-wins rule.

// File: rtl/irq_status_agg.sv
module irq_status_agg #(
  parameter int          AW            = 12,
  parameter int          SUB_W         = 16,
  parameter int          SUM_BIT       = 23,
  parameter logic [31:0] MAIN_MASK_RST = 32'hFF7F_FFFF,
  parameter logic [11:0] OFF_STAT      = 12'h100,
  parameter logic [11:0] OFF_MASK      = 12'h104,
  parameter logic [11:0] OFF_STAT_ALT  = 12'h108,
  parameter logic [11:0] OFF_MASK_ALT  = 12'h10C,
  parameter logic [11:0] OFF_SUB_STAT  = 12'h200,
  parameter logic [11:0] OFF_SUB_MASK  = 12'h204
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [31:0]   evt_set,
  input  logic [SUB_W-1:0] sub_set,
  output logic          irq
);

  localparam logic [31:0] SUM_ONLY = 32'h1 << SUM_BIT;

  logic [31:0]      main_stat, main_mask, stat_nxt;
  logic [SUB_W-1:0] sub_stat, sub_mask, sub_nxt;
  logic             sub_pend, irq_q;

  wire hit_stat = (bus_addr == AW'(OFF_STAT)) || (bus_addr == AW'(OFF_STAT_ALT));
  wire hit_mask = (bus_addr == AW'(OFF_MASK)) || (bus_addr == AW'(OFF_MASK_ALT));
  wire hit_sst  = (bus_addr == AW'(OFF_SUB_STAT));
  wire hit_smk  = (bus_addr == AW'(OFF_SUB_MASK));

  assign sub_pend = |(sub_stat & ~sub_mask);
  assign irq      = irq_q;

  always_comb begin
    stat_nxt = main_stat;
    if (bus_wr && hit_stat)      stat_nxt = bus_wdata;
    else if (bus_rd && hit_stat) stat_nxt = main_stat & SUM_ONLY;
    stat_nxt = stat_nxt | evt_set;

    sub_nxt = sub_stat;
    if (bus_wr && hit_sst)      sub_nxt = bus_wdata[SUB_W-1:0];
    else if (bus_rd && hit_sst) sub_nxt = '0;
    sub_nxt = sub_nxt | sub_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_stat <= '0;
      main_mask <= MAIN_MASK_RST;
      sub_stat  <= '0;
      sub_mask  <= '1;
      irq_q     <= 1'b0;
    end else begin
      main_stat <= stat_nxt;
      sub_stat  <= sub_nxt;
      if (bus_wr && hit_mask) main_mask <= bus_wdata;
      if (bus_wr && hit_smk)  sub_mask  <= bus_wdata[SUB_W-1:0];
      irq_q <= (|(main_stat & ~main_mask & ~SUM_ONLY)) | sub_pend;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_stat)     bus_rdata = main_stat | (32'(sub_pend) << SUM_BIT);
    else if (hit_mask) bus_rdata = main_mask;
    else if (hit_sst)  bus_rdata = 32'(sub_stat);
    else if (hit_smk)  bus_rdata = 32'(sub_mask);
  end

  p_bus_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (main_stat == 32'h0 && sub_stat == '0) |=> !irq);

  p_sum_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_stat == '0 && (main_stat & ~SUM_ONLY) == 32'h0) |=> !irq);

  p_rd_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_stat && evt_set == 32'h0) |=> ((main_stat & ~SUM_ONLY) == 32'h0));

  p_sub_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_sst && sub_set == '0) |=> (sub_stat == '0));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != 32'h0) |=> ((main_stat & $past(evt_set)) == $past(evt_set)));

  p_sub_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_set != '0) |=> ((sub_stat & $past(sub_set)) == $past(sub_set)));

endmodule

// File: tb/tb_irq_status_agg.sv
module tb_irq_status_agg;
  logic        clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0, evt_set = '0;
  logic [15:0] sub_set = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int tests = 0, fails = 0;
  bit done = 0;

  irq_status_agg dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
    .sub_set(sub_set), .irq(irq));

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic pulse(input logic [31:0] e, input logic [15:0] s);
    @(negedge clk); evt_set = e; sub_set = s;
    @(negedge clk); evt_set = '0; sub_set = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    check("R9 irq", {31'b0, irq}, 32'h0);
    rd(12'h104, d); check("R9 main mask", d, 32'hFF7F_FFFF);
    rd(12'h204, d); check("R9 sub mask R10", d, 32'h0000_FFFF);
    rd(12'h100, d); check("R9 main stat", d, 32'h0);
    rd(12'h200, d); check("R9 sub stat", d, 32'h0);
    rd(12'h300, d); check("R10 unmapped", d, 32'h0);

    // R1 R3 R8 sweep over every main bit
    for (int i = 0; i < 32; i++) begin
      wr(12'h104, ~(32'h1 << i));
      pulse(32'h1 << i, 16'h0);
      check("R8 irq not yet", {31'b0, irq}, 32'h0);
      tick();
      check("R1 irq per bit", {31'b0, irq}, (i == 23) ? 32'h0 : 32'h1);
      rd(12'h100, d);
      check("R4 read value", d, 32'h1 << i);
      rd(12'h100, d);
      check("R4 after clear", d, (i == 23) ? 32'h0080_0000 : 32'h0);
      wr(12'h100, 32'h0);
      tick();
      check("R1 irq drops", {31'b0, irq}, 32'h0);
    end

    // R1 masked bit stays silent
    wr(12'h104, 32'hFFFF_FFFF);
    pulse(32'h0001_0000, 16'h0); tick(); tick();
    check("R1 masked silent", {31'b0, irq}, 32'h0);
    rd(12'h100, d);

    // R2 R3 R5 sub-unit sweep, main mask fully set including bit 23
    for (int j = 0; j < 16; j++) begin
      wr(12'h204, ~(32'h1 << j));
      pulse(32'h0, 16'h1 << j);
      tick();
      check("R2 R3 sub irq", {31'b0, irq}, 32'h1);
      rd(12'h100, d);
      check("R2 summary bit", d, 32'h0080_0000);
      rd(12'h200, d);
      check("R5 sub value", d, 32'h1 << j);
      rd(12'h200, d);
      check("R5 sub cleared", d, 32'h0);
      tick();
      check("R5 irq drops", {31'b0, irq}, 32'h0);
    end
    // R2 masked sub bit
    wr(12'h204, 32'hFFFF);
    pulse(32'h0, 16'h0004); tick();
    rd(12'h100, d); check("R2 masked sub no summary", d, 32'h0);
    check("R2 masked sub no irq", {31'b0, irq}, 32'h0);
    rd(12'h200, d);

    // R3 written bit 23 with all enabled
    wr(12'h104, 32'h0);
    wr(12'h100, 32'h0080_0000); tick();
    check("R3 stored bit23 silent", {31'b0, irq}, 32'h0);
    rd(12'h100, d); rd(12'h100, d);
    check("R4 bit23 survives", d, 32'h0080_0000);
    wr(12'h100, 32'h0);

    // R6 aliases
    wr(12'h10C, 32'h1234_5678);
    rd(12'h104, d); check("R6 mask alias write", d, 32'h1234_5678);
    rd(12'h10C, d); check("R6 mask alias read", d, 32'h1234_5678);
    wr(12'h108, 32'h0300_0000);
    rd(12'h108, d); check("R6 stat alias read", d, 32'h0300_0000);
    rd(12'h100, d); check("R6 alias clears", d, 32'h0);

    // R7 set wins over clear-on-read
    @(negedge clk); bus_addr = 12'h100; bus_rd = 1; evt_set = 32'h0001_0000;
    @(negedge clk); bus_rd = 0; evt_set = '0;
    rd(12'h100, d); check("R7 set vs read", d, 32'h0001_0000);
    // R7 set wins over write
    @(negedge clk); bus_addr = 12'h100; bus_wdata = 32'h0; bus_wr = 1; evt_set = 32'h0100_0000;
    @(negedge clk); bus_wr = 0; evt_set = '0;
    rd(12'h100, d); check("R7 set vs write", d, 32'h0100_0000);
    // R7 sub set wins over read
    @(negedge clk); bus_addr = 12'h200; bus_rd = 1; sub_set = 16'h8000;
    @(negedge clk); bus_rd = 0; sub_set = '0;
    rd(12'h200, d); check("R7 sub set vs read", d, 32'h0000_8000);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule